// File: doc/BRIEF.md
# UART Transmitter with Half-Bit Stop Lengths

This block turns characters held in a 16-entry transmit queue into asynchronous serial frames on a single output line. Timing comes from an oversampling tick that pulses sixteen times per bit period. Each frame is a low start bit, then the data bits least significant first, then an optional parity bit. The line is then held high for a stop period. The stop period is counted in half-bit steps, so it can last half, one, one and a half or two bit times.

A 3-bit format code selects how many data bits are sent and whether parity follows. A separate select picks odd or even parity. When flow gating is enabled, the block waits to begin a new frame until the clear-to-send input is active. A frame that has already begun always runs to its end. The block also reports four queue and line conditions: transmitter idle, at least half empty, holding data, and full. A run control and a queue-flush input let the surrounding logic stop the line or discard pending characters.

Top module: `uart_tx_fstop`

## Requirements
- R1: After reset, `txd` is 1, `st_tx_idle` is 1, `st_half_free` is 1, `st_has_data` is 0 and `st_full` is 0.
- R2: A frame is a low start bit followed by the data bits sent least significant first. Every bit lasts 16 `tick16` pulses.
- R3: The format code `fmt` sets the data width. Code 3'b011 sends 7 data bits plus parity, and 3'b111 sends 8 data bits plus parity. Codes 3'b100 and 3'b101 send all 9 bits of the queued word with no parity. Every other code sends 8 data bits with no parity.
- R4: When `odd_par` is 0, the parity bit makes the number of ones across the data and parity bits even. When `odd_par` is 1, it makes that number odd.
- R5: The line stays high after the last frame bit for a stop period set by `stop_len`. The lengths are 00 = 8 ticks, 01 = 16, 10 = 24 and 11 = 32. When the queue is not empty, the next start bit begins as soon as the stop period ends.
- R6: The queue holds 16 words. A write while it is full is dropped, and the stored words are sent unchanged.
- R7: `st_has_data` is 1 when at least one word is queued. `st_half_free` is 1 when 8 or fewer are queued. `st_full` is 1 when 16 are queued.
- R8: `st_tx_idle` rises only when the queue is empty and the stop period of the last frame has ended. Its rise comes exactly 16·(frame bits) + 8·(stop_len+1) ticks after that frame's start bit began.
- R9: When `cts_gate` is 1 and `cts_n` is high, no new frame starts. `cts_n` passes through two synchronising flops before it is used. A frame that is already in progress completes.
- R10: When `run` is 0, `txd` is 1 from the next clock onward and no frame starts.
- R11: A pulse on `q_flush` empties the queue, so `st_has_data` reads 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling pulse, 16 per bit |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 9 | Word to queue |
| fmt | input | 3 | Frame format code |
| odd_par | input | 1 | 1 selects odd parity |
| stop_len | input | 2 | Stop period in half-bit steps minus one |
| cts_gate | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| run | input | 1 | Transmitter enable |
| q_flush | input | 1 | Empties the queue |
| txd | output | 1 | Serial line, idle high |
| st_tx_idle | output | 1 | Queue empty and line idle |
| st_half_free | output | 1 | At most half the queue used |
| st_has_data | output | 1 | Queue holds a word |
| st_full | output | 1 | Queue full |

## Verification
The end of one frame's stop period and the start of the next frame fall on the same tick. The stop counter expires, and the queue head is popped and loaded into the shifter in that same cycle. Bursts of random words are written faster than they can drain, so every frame after the first starts back to back. The bench measures the high time between each pair of frames in clock cycles and compares it with the stop length in force. A gap that is off by one tick shows a missed or doubled cycle at that junction.

// File: rtl/uart_tx_fstop.sv
module uart_tx_fstop #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  input  logic [2:0] fmt,
  input  logic       odd_par,
  input  logic [1:0] stop_len,
  input  logic       cts_gate,
  input  logic       cts_n,
  input  logic       run,
  input  logic       q_flush,
  output logic       txd,
  output logic       st_tx_idle,
  output logic       st_half_free,
  output logic       st_has_data,
  output logic       st_full
);
  localparam int DW   = 9;
  localparam int FB   = DW + 2;
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int TW   = $clog2(OSR);
  localparam int SW   = $clog2(2 * OSR);
  localparam int BW   = $clog2(FB + 1);
  localparam int HALF = OSR / 2;

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_STOP} st_t;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [1:0]    cts_q;
  st_t           state;
  logic [FB-1:0] sh, ld;
  logic [BW-1:0] nb_q, nb, bcnt;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] scnt, stop_last;
  logic [1:0]    stop_q;
  logic [3:0]    nd;
  logic          pen;
  logic [DW-1:0] dm;

  assign st_full      = cnt == CW'(DEPTH);
  assign st_has_data  = cnt != '0;
  assign st_half_free = cnt <= CW'(DEPTH / 2);
  assign st_tx_idle   = !st_has_data && state == S_IDLE;
  assign txd          = (state == S_BITS) ? sh[0] : 1'b1;

  wire push      = wr_en && !st_full && !q_flush;
  wire cts_ok    = !cts_gate || !cts_q[1];
  wire go        = run && tick16 && st_has_data && cts_ok && !q_flush;
  wire stop_done = state == S_STOP && tick16 && scnt == stop_last;
  wire start     = go && (state == S_IDLE || stop_done);

  assign stop_last = SW'(HALF * (int'(stop_q) + 1) - 1);

  always_comb begin
    case (fmt)
      3'b011:         begin nd = 4'd7; pen = 1'b1; end
      3'b111:         begin nd = 4'd8; pen = 1'b1; end
      3'b100, 3'b101: begin nd = 4'd9; pen = 1'b0; end
      default:        begin nd = 4'd8; pen = 1'b0; end
    endcase
    for (int i = 0; i < DW; i++) dm[i] = mem[rptr][i] && (4'(i) < nd);
    ld = FB'({dm, 1'b0});
    if (pen) ld[nd + 4'd1] = (^dm) ^ odd_par;
    nb = BW'(nd) + BW'(pen) + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_q <= 2'b11;
    else        cts_q <= {cts_q[0], cts_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (q_flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push)  wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (start) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(start);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sh     <= '1;
      nb_q   <= '0;
      bcnt   <= '0;
      tcnt   <= '0;
      scnt   <= '0;
      stop_q <= '0;
    end else if (!run) begin
      state <= S_IDLE;
    end else if (start) begin
      state  <= S_BITS;
      sh     <= ld;
      nb_q   <= nb;
      bcnt   <= '0;
      tcnt   <= '0;
      stop_q <= stop_len;
    end else if (tick16) begin
      case (state)
        S_BITS:
          if (tcnt == TW'(OSR - 1)) begin
            tcnt <= '0;
            if (bcnt == nb_q - 1'b1) begin
              state <= S_STOP;
              scnt  <= '0;
            end else begin
              sh   <= {1'b1, sh[FB-1:1]};
              bcnt <= bcnt + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        S_STOP:
          if (scnt == stop_last) state <= S_IDLE;
          else                   scnt  <= scnt + 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R6
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && wr_en && !q_flush) |=> $stable(wptr)); // R6
  AST_RUN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run |=> txd); // R10
  AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_gate && $past(cts_n, 2) && state == S_IDLE) |=> state == S_IDLE); // R9
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) st_tx_idle |-> txd); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(q_flush) |-> !st_has_data); // R11
endmodule

// File: tb/test_uart_tx_fstop.sv
module test_uart_tx_fstop;
  logic clk = 0, rst_n = 0, tick16 = 0;
  logic wr_en = 0, odd_par = 0, cts_gate = 0, cts_n = 0, run = 0, q_flush = 0;
  logic [8:0] wr_data = '0;
  logic [2:0] fmt = 3'b001;
  logic [1:0] stop_len = 2'b01;
  logic txd, st_tx_idle, st_half_free, st_has_data, st_full;

  typedef struct {logic [8:0] d; logic [2:0] m; logic o; logic [1:0] s;} ent_t;
  ent_t q[$];
  int checks = 0, fails = 0, frames = 0;
  bit mon_on = 1;

  uart_tx_fstop i_uart_tx_fstop (.*);

  always #10 clk = ~clk;
  always_ff @(posedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_nb(logic [2:0] m);
    case (m)
      3'b011: return 9;
      3'b111: return 10;
      3'b100, 3'b101: return 10;
      default: return 9;
    endcase
  endfunction

  function automatic logic [10:0] exp_bits(logic [8:0] d, logic [2:0] m, logic o);
    int nd; bit pe; logic p; logic [10:0] f;
    nd = (m == 3'b011) ? 7 : (m == 3'b100 || m == 3'b101) ? 9 : 8;
    pe = (m == 3'b011 || m == 3'b111);
    f = '0; p = o;
    for (int i = 0; i < nd; i++) begin f[i+1] = d[i]; p ^= d[i]; end
    if (pe) f[nd+1] = p;
    return f;
  endfunction

  // line monitor: R2 R3 R4 frame content, R5 gap between back-to-back frames
  initial begin
    bit have_fall = 0;
    forever begin
      if (!have_fall) @(negedge clk);
      have_fall = 0;
      if (mon_on && rst_n && txd === 1'b0) begin
        ent_t e; int nb, g; logic [10:0] obs;
        if (q.size() == 0) begin
          chk(0, "R2 unexpected frame", 1, 0);
          e = '{d: '0, m: 3'b001, o: 1'b0, s: 2'b00};
        end else e = q.pop_front();
        frames++;
        nb = exp_nb(e.m);
        obs = '0;
        repeat (16) @(negedge clk);
        obs[0] = txd;
        for (int i = 1; i < nb; i++) begin
          repeat (32) @(negedge clk);
          obs[i] = txd;
        end
        chk(obs == exp_bits(e.d, e.m, e.o), "R2 R3 R4 frame bits", obs, exp_bits(e.d, e.m, e.o));
        repeat (16) @(negedge clk);
        g = 0;
        while (txd === 1'b1 && g < 200) begin g++; @(negedge clk); end
        if (txd === 1'b0 && g < 200) begin
          chk(g == 16 * (e.s + 1), "R5 stop gap cycles", g, 16 * (e.s + 1));
          have_fall = 1;
        end
      end
    end
  end

  task automatic wr(logic [8:0] d, bit pe);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    if (pe) q.push_back('{d: d, m: fmt, o: odd_par, s: stop_len});
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int c = 0;
    while (!st_tx_idle && c < 20000) begin @(negedge clk); c++; end
    repeat (300) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1 && st_tx_idle == 1 && st_half_free == 1 && st_has_data == 0 && st_full == 0,
        "R1 reset state", {txd, st_tx_idle, st_half_free, st_has_data, st_full}, 5'b11100);
    run = 1;

    // R8: idle flag rises only after the stop period of the last frame
    fmt = 3'b001; stop_len = 2'b11;
    wr(9'h0A5, 1);
    while (txd !== 1'b0) @(negedge clk);
    chk(st_tx_idle == 0, "R8 not idle during frame", st_tx_idle, 0);
    begin
      int c = 0;
      while (!st_tx_idle && c < 2000) begin @(negedge clk); c++; end
      chk(c == 32 * 9 + 64, "R8 idle rise cycles", c, 32 * 9 + 64);
    end
    repeat (300) @(negedge clk);

    // R9 R6 R7: blocked by CTS, fill past full
    fmt = 3'b111; odd_par = 1; stop_len = 2'b00; cts_gate = 1; cts_n = 1;
    repeat (4) @(negedge clk);
    for (int k = 1; k <= 18; k++) begin
      wr(9'(k * 37 + 5), k <= 16);
      if (k <= 16)
        chk(st_has_data == 1 && st_half_free == (k <= 8) && st_full == (k == 16),
            "R7 flags while filling", {st_has_data, st_half_free, st_full},
            {1'b1, k <= 8, k == 16});
      else chk(st_full == 1, "R6 full holds after drop", st_full, 1);
    end
    repeat (200) @(negedge clk);
    chk(txd == 1 && frames == 1, "R9 no start while CTS high", frames, 1);
    cts_n = 0;
    wait_idle();
    chk(frames == 17 && q.size() == 0, "R6 sixteen words sent intact", frames, 17);

    // R9: CTS dropped mid-frame, frame completes, next one waits
    fmt = 3'b100; stop_len = 2'b10;
    wr(9'h1C3, 1); wr(9'h03C, 1);
    while (txd !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    cts_n = 1;
    repeat (32 * 10 + 400) @(negedge clk);
    chk(txd == 1 && st_has_data == 1 && frames == 18, "R9 held after finished frame", frames, 18);
    cts_n = 0; cts_gate = 0;
    wait_idle();
    chk(frames == 19, "R9 second frame after release", frames, 19);

    // random bursts: R2 R3 R4 R5
    for (int b = 0; b < 8; b++) begin
      fmt = 3'($urandom_range(0, 7)); odd_par = 1'($urandom_range(0, 1));
      stop_len = 2'(b % 4);
      for (int n = 0; n < int'($urandom_range(2, 8)); n++) wr(9'($urandom), 1);
      wait_idle();
    end
    chk(q.size() == 0, "R2 all random frames seen", q.size(), 0);

    // R10 R11: run low aborts and blocks, flush empties
    mon_on = 0;
    wr(9'h055, 0);
    while (txd !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    run = 0;
    @(negedge clk);
    chk(txd == 1, "R10 line high after run low", txd, 1);
    wr(9'h011, 0); wr(9'h022, 0); wr(9'h033, 0);
    repeat (200) @(negedge clk);
    chk(txd == 1 && st_has_data == 1, "R10 no start while run low", txd, 1);
    @(negedge clk); q_flush = 1; @(negedge clk); q_flush = 0;
    chk(st_has_data == 0 && st_tx_idle == 1 && st_half_free == 1, "R11 flush empties queue",
        st_has_data, 0);
    run = 1;
    repeat (200) @(negedge clk);
    chk(txd == 1, "R11 nothing sent after flush", txd, 1);
    finish_run();
  end
endmodule